// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the eight-bit status word of a small accumulator-style processor core. It holds three arithmetic flags (zero, nibble carry, carry), two power-state latches (time-out and power-down), and three bank-select bits that extend data-memory addresses. Each cycle it takes the operands and operation code of the current instruction, forms the ALU result and its carry-outs, and resolves those flags against a write that names the status word itself as destination. Watchdog expiry, sleep entry and watchdog-clear pulses drive the two power latches, which software cannot write.

The bank bits are also presented as finished addresses. Two bank bits sit above a 7-bit direct address, and the top bank bit sits above an 8-bit indirect address. This lets the memory array use the register without decoding it again.

Subtraction is done by adding the inverted second operand with a carry-in of one. The carry and nibble-carry flags therefore read 1 when no borrow happened. The rotate operations feed the current carry into the vacated bit and move the shifted-out bit into carry.

Top module: `stat_flag_reg`

## Requirements
- R1: Bits 7:5 (indirect bank, direct bank high, direct bank low) load from `wr_data_i[7:5]` on a cycle with `wr_hit_i` high, and hold their value otherwise.
- R2: Z (bit 2) becomes 1 exactly when the 8-bit result is zero, and is recomputed only in cycles with `aff_z_i` high.
- R3: Operation code 0 (add) gives `res_o = opa_i + opb_i` mod 256. C (bit 0) is the carry out of bit 7 and DC (bit 1) is the carry out of bit 3.
- R4: Operation code 1 (subtract) gives `res_o = opa_i - opb_i` mod 256. C is 1 when `opa_i >= opb_i`, and DC is 1 when `opa_i[3:0] >= opb_i[3:0]`.
- R5: Code 5 (rotate right) gives `{C, opa_i[7:1]}` and loads C from `opa_i[0]`. Code 6 (rotate left) gives `{opa_i[6:0], C}` and loads C from `opa_i[7]`.
- R6: If any of `aff_z_i`, `aff_dc_i`, `aff_c_i` is high, a write to the register leaves Z, DC and C untouched. Each enabled flag takes its computed value and each flag that is not enabled holds. With no enable high, a write loads bits 2:0 from `wr_data_i[2:0]`.
- R7: TO (bit 4) and PD (bit 3) never take values from `wr_data_i`. With no event pulse they hold, even during a write.
- R8: `wdt_to_i` clears TO and leaves PD unchanged. Otherwise `sleep_i` sets TO and clears PD. Otherwise `clrwdt_i` sets both. The priority is time-out, then sleep, then clear.
- R9: While `rst_ni` is low, the register reads 0x18: bank bits 0, TO and PD 1, and Z, DC, C 0.
- R10: `dir_addr_o = {bit6, bit5, dir_addr_i}` and `ind_addr_o = {bit7, ind_addr_i}`, with no delay.
- R11: Code 7 (clear) gives result 0. A clear aimed at the register with `wr_data_i = 0` and only `aff_z_i` high leaves bits 7:5 at 0, sets Z, and keeps TO, PD, DC and C.
- R12: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_hit_i | input | 1 | The current instruction writes this register |
| wr_data_i | input | 8 | Write data |
| aff_z_i | input | 1 | The instruction updates Z |
| aff_dc_i | input | 1 | The instruction updates DC |
| aff_c_i | input | 1 | The instruction updates C |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 rotate right, 6 rotate left, 7 clear) |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| wdt_to_i | input | 1 | Watchdog expiry pulse |
| sleep_i | input | 1 | Sleep entry pulse |
| clrwdt_i | input | 1 | Watchdog clear pulse |
| dir_addr_i | input | 7 | Direct address offset |
| ind_addr_i | input | 8 | Indirect address offset |
| res_o | output | 8 | ALU result |
| stat_o | output | 8 | Register contents |
| dir_addr_o | output | 9 | Banked direct address |
| ind_addr_o | output | 9 | Banked indirect address |

## Verification
The assertions check the following on every cycle:
- the event priority on TO and PD;
- TO and PD holding when no event arrives;
- bank bits holding when there is no write, and a written bank reaching the direct address one cycle later;
- unenabled flags holding while an instruction blocks a write;
- the add and subtract carries matching an independent magnitude comparison.

Only the bench scenarios show the full expected values: the exact results of each operation, the carry chaining through successive rotates, the reset value, and the combined outcome of a clear aimed at the register itself.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int DW  = 8;
  localparam int NIB = DW / 2;
  localparam int NFL = 3;

  // bit positions inside the status word
  localparam int B_IRP = 7;
  localparam int B_RP1 = 6;
  localparam int B_RP0 = 5;
  localparam int B_TO  = 4;
  localparam int B_PD  = 3;
  localparam int B_Z   = 2;
  localparam int B_DC  = 1;
  localparam int B_C   = 0;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_IOR = 3'd3,
    OP_XOR = 3'd4,
    OP_RRF = 3'd5,
    OP_RLF = 3'd6,
    OP_CLR = 3'd7
  } op_e;
endpackage

// File: rtl/stat_alu.sv
module stat_alu
  import stat_pkg::*;
(
  input  op_e             op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            c_i,
  output logic [DW-1:0]   res_o,
  output logic [NFL-1:0]  fl_o    // {z, dc, c}
);
  logic          sub;
  logic [DW-1:0] bx;
  logic [DW:0]   sum;
  logic          c_n;

  always_comb begin
    sub = (op_i == OP_SUB);
    bx  = sub ? ~b_i : b_i;
    sum = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, sub};
    res_o = sum[DW-1:0];
    c_n   = sum[DW];
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_IOR: res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_RRF: begin
        res_o = {c_i, a_i[DW-1:1]};
        c_n   = a_i[0];
      end
      OP_RLF: begin
        res_o = {a_i[DW-2:0], c_i};
        c_n   = a_i[DW-1];
      end
      OP_CLR: res_o = '0;
      default: ;
    endcase
    // carry into bit NIB equals carry out of the low nibble
    fl_o[B_DC] = a_i[NIB] ^ bx[NIB] ^ sum[NIB];
    fl_o[B_C]  = c_n;
    fl_o[B_Z]  = (res_o == '0);
  end

  always_comb begin
    if (op_i == OP_SUB)
      a_r4_sub_no_borrow: assert (fl_o[B_C] == (a_i >= b_i));
    if (op_i == OP_ADD)
      a_r3_add_carry: assert (fl_o[B_C] == (({1'b0, a_i} + {1'b0, b_i}) > {1'b0, {DW{1'b1}}}));
  end
endmodule

// File: rtl/stat_arith_bits.sv
module stat_arith_bits
  import stat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_hit_i,
  input  logic [NFL-1:0]  wr_i,
  input  logic [NFL-1:0]  aff_i,
  input  logic [NFL-1:0]  calc_i,
  output logic [NFL-1:0]  q_o
);
  logic blk;
  assign blk = |aff_i;  // any affected flag blocks the whole write to the group

  for (genvar k = 0; k < NFL; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 bit_q <= 1'b0;
      else if (aff_i[k])           bit_q <= calc_i[k];
      else if (wr_hit_i && !blk)   bit_q <= wr_i[k];
    end
    assign q_o[k] = bit_q;

    a_r6_blocked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk && !aff_i[k]) |=> $stable(q_o[k]));
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!aff_i[k] && !wr_hit_i) |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/stat_pwr_bits.sv
module stat_pwr_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_to_i,
  input  logic sleep_i,
  input  logic clrwdt_i,
  output logic to_o,
  output logic pd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_o <= 1'b1;
      pd_o <= 1'b1;
    end else if (wdt_to_i) begin
      to_o <= 1'b0;
    end else if (sleep_i) begin
      to_o <= 1'b1;
      pd_o <= 1'b0;
    end else if (clrwdt_i) begin
      to_o <= 1'b1;
      pd_o <= 1'b1;
    end
  end

  a_r8_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_i |=> (!to_o && $stable(pd_o)));
  a_r8_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !wdt_to_i) |=> (to_o && !pd_o));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clrwdt_i && !sleep_i && !wdt_to_i) |=> (to_o && pd_o));
  a_r7_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clrwdt_i && !sleep_i && !wdt_to_i) |=> ($stable(to_o) && $stable(pd_o)));
endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int DIR_AW = 7,
  parameter int IND_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [2:0]        wr_i,       // {irp, rp1, rp0}
  input  logic [DIR_AW-1:0] dir_addr_i,
  input  logic [IND_AW-1:0] ind_addr_i,
  output logic [2:0]        bank_o,
  output logic [DIR_AW+1:0] dir_addr_o,
  output logic [IND_AW:0]   ind_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_o <= '0;
    else if (wr_hit_i) bank_o <= wr_i;
  end

  assign dir_addr_o = {bank_o[1:0], dir_addr_i};
  assign ind_addr_o = {bank_o[2], ind_addr_i};

  a_r1_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(bank_o));
  a_r10_dir_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> (dir_addr_o[DIR_AW +: 2] == $past(wr_i[1:0])));
endmodule

// File: rtl/stat_flag_reg.sv
module stat_flag_reg
  import stat_pkg::*;
#(
  parameter int DIR_AW = 7,
  parameter int IND_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [7:0]        wr_data_i,
  input  logic              aff_z_i,
  input  logic              aff_dc_i,
  input  logic              aff_c_i,
  input  logic [2:0]        op_i,
  input  logic [7:0]        opa_i,
  input  logic [7:0]        opb_i,
  input  logic              wdt_to_i,
  input  logic              sleep_i,
  input  logic              clrwdt_i,
  input  logic [DIR_AW-1:0] dir_addr_i,
  input  logic [IND_AW-1:0] ind_addr_i,
  output logic [7:0]        res_o,
  output logic [7:0]        stat_o,
  output logic [DIR_AW+1:0] dir_addr_o,
  output logic [IND_AW:0]   ind_addr_o
);
  logic [NFL-1:0] aff, calc, fl_q;
  logic [2:0]     bank;
  logic           to_q, pd_q;
  logic           any_evt;

  assign aff     = {aff_z_i, aff_dc_i, aff_c_i};
  assign any_evt = wdt_to_i | sleep_i | clrwdt_i;

  stat_alu u_alu (
    .op_i  (op_e'(op_i)),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .c_i   (fl_q[B_C]),
    .res_o (res_o),
    .fl_o  (calc)
  );

  stat_arith_bits u_arith (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit_i),
    .wr_i     (wr_data_i[NFL-1:0]),
    .aff_i    (aff),
    .calc_i   (calc),
    .q_o      (fl_q)
  );

  stat_pwr_bits u_pwr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdt_to_i (wdt_to_i),
    .sleep_i  (sleep_i),
    .clrwdt_i (clrwdt_i),
    .to_o     (to_q),
    .pd_o     (pd_q)
  );

  stat_bank #(.DIR_AW(DIR_AW), .IND_AW(IND_AW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hit_i   (wr_hit_i),
    .wr_i       (wr_data_i[B_IRP:B_RP0]),
    .dir_addr_i (dir_addr_i),
    .ind_addr_i (ind_addr_i),
    .bank_o     (bank),
    .dir_addr_o (dir_addr_o),
    .ind_addr_o (ind_addr_o)
  );

  assign stat_o = {bank, to_q, pd_q, fl_q};

  a_r7_to_unwritable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && !any_evt && (wr_data_i[B_TO] != stat_o[B_TO])) |=> $stable(stat_o[B_TO]));
  a_r7_pd_unwritable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && !any_evt && (wr_data_i[B_PD] != stat_o[B_PD])) |=> $stable(stat_o[B_PD]));
  a_r2_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aff_z_i |=> (stat_o[B_Z] == ($past(res_o) == 8'h00)));
endmodule

// File: tb/sim_stat_flag_reg.sv
module sim_stat_flag_reg;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       wr_hit;
  logic [7:0] wr_data;
  logic       aff_z, aff_dc, aff_c;
  logic [2:0] op;
  logic [7:0] opa, opb;
  logic       wdt, slp, clr;
  logic [6:0] dir_in;
  logic [7:0] ind_in;
  logic [7:0] res, stat;
  logic [8:0] dir_out, ind_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stat_flag_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_hit_i(wr_hit), .wr_data_i(wr_data),
    .aff_z_i(aff_z), .aff_dc_i(aff_dc), .aff_c_i(aff_c), .op_i(op),
    .opa_i(opa), .opb_i(opb), .wdt_to_i(wdt), .sleep_i(slp), .clrwdt_i(clr),
    .dir_addr_i(dir_in), .ind_addr_i(ind_in), .res_o(res), .stat_o(stat),
    .dir_addr_o(dir_out), .ind_addr_o(ind_out)
  );

  // {op, a, b, aff(z,dc,c), exp_res, exp_flags(z,dc,c)}; bank 0, TO=PD=1 during the walk
  localparam logic [32:0] VEC [16] = '{
    {3'd0, 8'h0F, 8'h01, 3'b111, 8'h10, 3'b010},  // R3
    {3'd0, 8'hF0, 8'h10, 3'b111, 8'h00, 3'b101},  // R3 R2
    {3'd0, 8'hFF, 8'h01, 3'b111, 8'h00, 3'b111},  // R3
    {3'd1, 8'h05, 8'h03, 3'b111, 8'h02, 3'b011},  // R4
    {3'd1, 8'h03, 8'h05, 3'b111, 8'hFE, 3'b000},  // R4
    {3'd1, 8'h10, 8'h01, 3'b111, 8'h0F, 3'b001},  // R4 nibble borrow
    {3'd1, 8'h22, 8'h22, 3'b111, 8'h00, 3'b111},  // R4
    {3'd5, 8'h81, 8'h00, 3'b001, 8'hC0, 3'b111},  // R5
    {3'd6, 8'h40, 8'h00, 3'b001, 8'h81, 3'b110},  // R5
    {3'd6, 8'h80, 8'h00, 3'b001, 8'h00, 3'b111},  // R5, Z untouched
    {3'd2, 8'hF0, 8'h0F, 3'b100, 8'h00, 3'b111},  // R12
    {3'd3, 8'h0A, 8'h50, 3'b100, 8'h5A, 3'b011},  // R12
    {3'd4, 8'h3C, 8'h3C, 3'b100, 8'h00, 3'b111},  // R12
    {3'd0, 8'h08, 8'h08, 3'b111, 8'h10, 3'b010},  // R3
    {3'd5, 8'h02, 8'h00, 3'b001, 8'h01, 3'b010},  // R5
    {3'd7, 8'h55, 8'hAA, 3'b100, 8'h00, 3'b110}   // R11
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, come back to negedge
  task automatic cyc(input logic w, input logic [7:0] wd, input logic [2:0] af,
                     input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                     input logic e_w, input logic e_s, input logic e_c);
    wr_hit = w; wr_data = wd; {aff_z, aff_dc, aff_c} = af;
    op = o; opa = a; opb = b; wdt = e_w; slp = e_s; clr = e_c;
    @(posedge clk);
    @(negedge clk);
    wr_hit = 0; {aff_z, aff_dc, aff_c} = 3'b000; wdt = 0; slp = 0; clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..all act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 0; wr_hit = 0; wr_data = 0; {aff_z, aff_dc, aff_c} = 3'b000;
    op = 0; opa = 0; opb = 0; wdt = 0; slp = 0; clr = 0; dir_in = 0; ind_in = 0;
    repeat (2) @(negedge clk);
    chk("R9 reset value", {8'h0, stat}, 16'h0018);
    rst_ni = 1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      op = VEC[i][32:30]; opa = VEC[i][29:22]; opb = VEC[i][21:14];
      {aff_z, aff_dc, aff_c} = VEC[i][13:11];
      #1;
      chk($sformatf("R3/R4/R5/R11/R12 result vec %0d", i), {8'h0, res}, {8'h0, VEC[i][10:3]});
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5/R6 flags vec %0d", i), {8'h0, stat}, {8'h0, 5'b00011, VEC[i][2:0]});
    end
    {aff_z, aff_dc, aff_c} = 3'b000;

    cyc(1, 8'h00, 3'b000, 3'd0, 8'h0, 8'h0, 0, 0, 0);
    chk("R1 R6 plain write", {8'h0, stat}, 16'h0018);
    cyc(0, 8'h00, 3'b000, 3'd0, 8'h0, 8'h0, 1, 0, 0);
    chk("R8 expiry", {8'h0, stat}, 16'h0008);
    cyc(1, 8'hFF, 3'b000, 3'd0, 8'h0, 8'h0, 0, 0, 0);
    chk("R7 write cannot set TO", {8'h0, stat}, 16'h00EF);
    dir_in = 7'h05; ind_in = 8'h34; #1;
    chk("R10 direct address bank 3", {7'h0, dir_out}, 16'h0185);
    chk("R10 indirect address upper", {7'h0, ind_out}, 16'h0134);
    cyc(1, 8'h40, 3'b000, 3'd0, 8'h0, 8'h0, 0, 0, 0);
    chk("R1 bank write", {8'h0, stat}, 16'h0048);
    chk("R10 direct address bank 2", {7'h0, dir_out}, 16'h0105);
    chk("R10 indirect address lower", {7'h0, ind_out}, 16'h0034);
    cyc(1, 8'hA0, 3'b111, 3'd0, 8'hFF, 8'h01, 0, 0, 0);
    chk("R6 computed flags beat write", {8'h0, stat}, 16'h00AF);
    cyc(1, 8'h00, 3'b001, 3'd0, 8'h01, 8'h01, 0, 0, 0);
    chk("R6 partial enable blocks group", {8'h0, stat}, 16'h000E);
    cyc(1, 8'h05, 3'b000, 3'd0, 8'h0, 8'h0, 0, 0, 0);
    chk("R6 unblocked flag write", {8'h0, stat}, 16'h000D);
    cyc(0, 8'h00, 3'b000, 3'd0, 8'h0, 8'h0, 0, 1, 0);
    chk("R8 sleep", {8'h0, stat}, 16'h0015);
    cyc(1, 8'h00, 3'b000, 3'd0, 8'h0, 8'h0, 0, 0, 1);
    chk("R8 R7 clear with write", {8'h0, stat}, 16'h0018);
    cyc(0, 8'h00, 3'b000, 3'd0, 8'h0, 8'h0, 1, 1, 0);
    chk("R8 expiry beats sleep", {8'h0, stat}, 16'h0008);
    cyc(0, 8'h00, 3'b000, 3'd0, 8'h0, 8'h0, 0, 1, 1);
    chk("R8 sleep beats clear", {8'h0, stat}, 16'h0010);
    cyc(1, 8'hE7, 3'b000, 3'd0, 8'h0, 8'h0, 0, 0, 0);
    chk("R1 R6 full write", {8'h0, stat}, 16'h00F7);
    cyc(1, 8'h00, 3'b100, 3'd7, 8'h0, 8'h0, 0, 0, 0);
    chk("R11 clear into register", {8'h0, stat}, 16'h0017);
    cyc(0, 8'hFF, 3'b000, 3'd0, 8'h0, 8'h0, 0, 0, 0);
    chk("R1 R2 idle hold", {8'h0, stat}, 16'h0017);

    rst_ni = 0; #1;
    chk("R9 async reset", {8'h0, stat}, 16'h0018);
    @(negedge clk);
    rst_ni = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule